// File: doc/BRIEF.md
# Length-Tagged Golomb-Rice Sample Decoder

This block turns one code word of a modified Golomb-Rice code back into the 10-bit sample it came from. The divisor is fixed at 128, so every word ends in a 7-bit remainder. In front of the remainder is a prefix that carries the quotient (0 to 7). An upstream bit extractor delivers each word left-aligned in a 12-bit field, together with its length in bits. The block has no bitstream parsing of its own.

The length tag selects how the prefix is read:

- **9-bit words** carry a two-bit lookup prefix. This prefix stands for quotient 1 or for one of the three largest quotients, which the encoder shortened.
- **All other legal lengths** carry an ordinary unary prefix: a run of ones ended by a zero.

Every word is checked against the prefix its length allows. A mismatch, or a length outside 8 to 12, produces an error result in place of a sample.

Results leave through a single registered valid/ready stage. A stalled output stage holds off new input.

Top module: `gr_len_decoder`

## Requirements
- R1: The word is left-aligned in `in_code` (its first bit is bit 11). The remainder is the last 7 valid bits of the word, which are bits `18-len` down to `12-len`. Bits below the word are ignored.
- R2: Length 8. Bit 11 must be 0, and the quotient is 0. If bit 11 is 1, the result is an error.
- R3: Length 9. Bits 11:10 alone select the quotient: `10` gives 1, `00` gives 5, `01` gives 6 and `11` gives 7. No 9-bit word is an error.
- R4: Lengths 10, 11 and 12. The word must start with `len-8` ones followed by a zero. The quotient is then 2, 3 or 4. Any other start is an error.
- R5: A length outside 8 to 12 is an error. An error result has `out_err` = 1 and `out_sample` = 0.
- R6: A valid result has `out_err` = 0 and `out_sample` = quotient × 128 + remainder.
- R7: An input that is accepted (`in_valid` and `in_ready` high at a clock edge) appears on the outputs, with `out_valid` high, just after that same edge.
- R8: `in_ready` is high exactly when the output stage is empty or is being drained in this cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample` and `out_err` hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Code word present |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_code | input | 12 | Left-aligned code word |
| in_len | input | 4 | Code word length in bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sample | output | 10 | Reconstructed sample |
| out_err | output | 1 | Illegal length or prefix |

## Verification
Draining a held result and accepting the next word can happen on the same clock edge. In that case the output register must be overwritten with the new result, and the old result must not be lost or duplicated. The bench provokes this by keeping words always offered while `out_ready` follows an irregular pattern: long runs high, with scattered low cycles. A scoreboard queue matches results in order, so any dropped or repeated result shows up as a mismatch. Every stalled cycle is also compared with the previous one to confirm the output held still.

// File: rtl/gr_len_decoder.sv
module gr_len_decoder #(
  parameter int REM_W  = 7,
  parameter int CODE_W = 12,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REM_W+2:0]  out_sample,
  output logic              out_err
);
  localparam int Q_W = 3;

  logic [Q_W-1:0]   q;
  logic [REM_W-1:0] rem;
  logic             ok;

  always_comb begin
    q   = '0;
    rem = '0;
    ok  = 1'b0;
    case (in_len)
      4'd8: begin
        ok  = !in_code[11];
        rem = in_code[10:4];
      end
      4'd9: begin
        ok  = 1'b1;
        rem = in_code[9:3];
        case (in_code[11:10])
          2'b10:   q = 3'd1;
          2'b00:   q = 3'd5;
          2'b01:   q = 3'd6;
          default: q = 3'd7;
        endcase
      end
      4'd10: begin
        ok  = (in_code[11:9] == 3'b110);
        q   = 3'd2;
        rem = in_code[8:2];
      end
      4'd11: begin
        ok  = (in_code[11:8] == 4'b1110);
        q   = 3'd3;
        rem = in_code[7:1];
      end
      4'd12: begin
        ok  = (in_code[11:7] == 5'b11110);
        q   = 3'd4;
        rem = in_code[6:0];
      end
      default: ok = 1'b0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  wire accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_err    <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_err    <= !ok;
      out_sample <= ok ? {q, rem} : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  p_accept_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample) && $stable(out_err));

  p_bad_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_len < 4'd8 || in_len > 4'd12) |=> out_err && out_sample == '0);

  p_nine_never_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_len == 4'd9 |=> !out_err && out_sample[9:7] != 3'd0);

  p_eight_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_len == 4'd8 && !in_code[11] |=> !out_err && out_sample[9:7] == 3'd0);
endmodule

// File: tb/tb_gr_len_decoder.sv
module tb_gr_len_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_code = '0;
  logic [3:0] in_len = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [9:0] out_sample;
  logic out_err;

  always #4 clk = ~clk;

  gr_len_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .out_err(out_err)
  );

  int checks = 0;
  int failures = 0;
  int total_bits = 0;
  bit sending_done = 1'b0;
  logic [10:0] expq[$];
  string tagq[$];

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void encode(input int v, output logic [11:0] code, output int len);
    int q, r, pre, plen;
    q = v / 128;
    r = v % 128;
    case (q)
      0: begin pre = 0;      plen = 1; end
      1: begin pre = 2'b10;  plen = 2; end
      2: begin pre = 3'b110; plen = 3; end
      3: begin pre = 4'b1110; plen = 4; end
      4: begin pre = 5'b11110; plen = 5; end
      5: begin pre = 2'b00;  plen = 2; end
      6: begin pre = 2'b01;  plen = 2; end
      default: begin pre = 2'b11; plen = 2; end
    endcase
    len = plen + 7;
    code = 12'(((pre << 7) | r) << (12 - len));
  endfunction

  task automatic send(input logic [11:0] code, input logic [3:0] len,
                      input bit err, input int sample, input string tag);
    bit ok;
    expq.push_back({err, 10'(sample)});
    tagq.push_back(tag);
    in_valid = 1'b1;
    in_code = code;
    in_len = len;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  bit prev_stall = 1'b0;
  logic [10:0] prev_out;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (prev_stall)
        check({out_err, out_sample} == prev_out, "R8 hold", {out_err, out_sample}, prev_out);
      if (out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 unexpected result", {out_err, out_sample}, -1);
        end else begin
          logic [10:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check({out_err, out_sample} == e, t, {out_err, out_sample}, e);
        end
      end
      prev_stall = !out_ready;
      prev_out = {out_err, out_sample};
    end else begin
      prev_stall = 1'b0;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (cyc < 300) out_ready = 1'b1;
      else if (cyc < 900) out_ready = (cyc % 3) != 0;
      else out_ready = (cyc % 7) != 2 && (cyc % 11) != 5;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] c;
    int l;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 1024; v++) begin
      encode(v, c, l);
      total_bits += l;
      case (l)
        8: send(c, 4'(l), 1'b0, v, "R2 R6 len8");
        9: send(c, 4'(l), 1'b0, v, "R3 R6 len9");
        default: send(c, 4'(l), 1'b0, v, "R4 R6 long");
      endcase
    end
    check(total_bits == 9856, "R6 total bits", total_bits, 9856);
    send(12'b0101_0101_0111, 4'd8, 1'b0, 10'h55, "R1 trailing ignored");
    send(12'b1000_0000_0000, 4'd8, 1'b1, 0, "R2 bad len8");
    send(12'b1110_0000_0000, 4'd10, 1'b1, 0, "R4 bad len10");
    send(12'b1100_0000_0000, 4'd11, 1'b1, 0, "R4 bad len11");
    send(12'b1111_1000_0000, 4'd12, 1'b1, 0, "R4 bad len12");
    send(12'b0000_0000_0000, 4'd7, 1'b1, 0, "R5 len7");
    send(12'b0000_0000_0000, 4'd13, 1'b1, 0, "R5 len13");
    send(12'b0000_0001_0000, 4'd0, 1'b1, 0, "R5 len0");
    send(12'b0011_1111_1000, 4'd9, 1'b0, 5*128+127, "R3 q5 max");
    sending_done = 1'b1;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule